// File: doc/BRIEF.md
# Command-Controlled Interval Timer Interface

This block sits on a small parallel bus and controls a down-counting interval timer. A write to the control address stores one command byte. Six of its bits drive the port-mode and port interrupt-enable outputs. The top two bits carry a timer command: no-operation, halt now, halt at the end of the current period, or start. Two further addresses hold a 14-bit count length and a 2-bit timer mode. The timer decrements once per `tmr_tick` cycle. When it passes through a count of one it marks terminal count and either reloads or stops.

A read at the control address returns a status word. The status word holds six port handshake flags, which arrive as plain inputs, and a sticky timer-done flag. Each status read clears the sticky flag. If terminal count arrives in the same cycle as a status read, the flag stays set, so the event is not lost.

A start issued while the timer runs does not cut the current period short. The new length and mode wait and take effect at the next terminal count. A halt-at-terminal-count request and a deferred start replace each other: the later one wins.

Top module: `ivt_cmd_unit`

## Requirements
- R1: Bus decode and the command register.
  - A control write needs `bus_cs`=1, `bus_io`=1, `bus_wr`=1 and `bus_addr`=0.
  - It stores `bus_wdata[3:0]` on `port_mode` and `bus_wdata[5:4]` on `port_irq_en` from the next cycle.
  - Both outputs hold between control writes.
  - Reset clears both outputs to zero.
- R2: Timer command 00 (`bus_wdata[7:6]`) leaves the run state and the counter unchanged. Its other six bits are still stored.
- R3: Timer command 01 stops a running timer at once, and `tmr_count` then holds its value. On an idle timer it has no effect.
- R4: Timer command 10 on a running timer lets the current period finish.
  - The timer stops at the tick that reaches terminal count.
  - On an idle timer the command has no effect.
- R5: Timer command 11 on an idle timer copies the length registers into the active length and mode and starts the timer.
  - From the next cycle, `tmr_count` equals the length.
  - Each `tmr_tick` cycle lowers the count by one.
  - The tick taken at count 1 is terminal count, so terminal count is reached L ticks after the start.
  - The length must be at least 2.
- R6: Timer command 11 on a running timer leaves the current period untouched.
  - At the next terminal count the timer reloads from the length registers as they hold at that moment.
  - It keeps running, whatever the new mode.
- R7: A pending halt-at-terminal-count request and a pending deferred start cancel each other. The later of the two commands decides what happens at terminal count.
- R8: Mode encoding: 00 single pulse, 01 single square, 10 continuous pulse, 11 continuous square.
  - At terminal count, with no deferred start pending, a single mode stops the timer.
  - A continuous mode reloads the count.
  - In both cases `tmr_count` becomes the active length.
- R9: A control-address read needs `bus_cs`, `bus_io` and `bus_rd` all at 1. In that cycle `bus_rdata` shows the status word.
  - Bits 5:0 are `port_flags`.
  - Bit 6 is the timer flag.
  - Bit 7 is 0.
  - Every other cycle returns 0.
- R10: The timer flag is set by terminal count and cleared by a status read or reset.
  - A status read in the same cycle as terminal count returns the old value and leaves the flag set.
- R11: Length registers.
  - Address 4 takes length bits 7:0.
  - Address 5 takes length bits 13:8 from `bus_wdata[5:0]` and the mode from `bus_wdata[7:6]`.
- R12: `tmr_out` depends on the mode while the timer runs, and is 1 while it is stopped.
  - Pulse modes: it is 0 only while the count is 1.
  - Square modes: it is 1 while the count exceeds half the active length, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_io | input | 1 | 1 selects the I/O space |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational in the read cycle |
| port_flags | input | 6 | Port handshake flags passed into status |
| tmr_tick | input | 1 | Timer count enable |
| port_mode | output | 4 | Stored port mode bits |
| port_irq_en | output | 2 | Stored port interrupt enables |
| tmr_out | output | 1 | Timer waveform |
| tmr_run | output | 1 | Timer running |
| tmr_count | output | 14 | Current count value |

## Verification
The bench uses the default 14-bit length. This lets a vector load a length above 255, which exercises the high length register and the borrow across the byte boundary. Short lengths of 2 to 6 bring terminal count, the deferred reload, the halt-at-end-of-period request and the coincidence of a read with terminal count within a few ticks. The mode vectors cover all four mode encodings.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    TC_NOP   = 2'b00,
    TC_HALT  = 2'b01,
    TC_DRAIN = 2'b10,
    TC_GO    = 2'b11
  } tcmd_e;

  localparam logic [2:0] A_CTL    = 3'd0;
  localparam logic [2:0] A_LEN_LO = 3'd4;
  localparam logic [2:0] A_LEN_HI = 3'd5;
endpackage

// File: rtl/ivt_bus_dec.sv
module ivt_bus_dec
  import ivt_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             io,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic             ctl_wr,
  output logic             stat_rd,
  output tcmd_e            tcmd,
  output logic [5:0]       cmd_q,
  output logic [LEN_W-1:0] pend_len,
  output logic [1:0]       pend_mode
);
  localparam int HI_W = LEN_W - 8;

  logic             sel;
  logic             lo_wr, hi_wr;
  logic [5:0]       cmd_n;
  logic [7:0]       lo_q, lo_n;
  logic [HI_W-1:0]  hi_q, hi_n;
  logic [1:0]       mode_q, mode_n;

  assign sel     = cs && io;
  assign ctl_wr  = sel && wr && (addr == A_CTL);
  assign stat_rd = sel && rd && (addr == A_CTL);
  assign lo_wr   = sel && wr && (addr == A_LEN_LO);
  assign hi_wr   = sel && wr && (addr == A_LEN_HI);
  assign tcmd    = tcmd_e'(wdata[7:6]);

  always_comb begin
    cmd_n  = cmd_q;
    lo_n   = lo_q;
    hi_n   = hi_q;
    mode_n = mode_q;
    if (ctl_wr) cmd_n = wdata[5:0];
    if (lo_wr)  lo_n  = wdata;
    if (hi_wr) begin
      hi_n   = wdata[HI_W-1:0];
      mode_n = wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      mode_q <= mode_n;
    end
  end

  assign pend_len  = {hi_q, lo_q};
  assign pend_mode = mode_q;

  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(cmd_q));
endmodule

// File: rtl/ivt_run_fsm.sv
module ivt_run_fsm
  import ivt_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_wr,
  input  tcmd_e            tcmd,
  input  logic [LEN_W-1:0] pend_len,
  input  logic [1:0]       pend_mode,
  output logic             run,
  output logic [LEN_W-1:0] cnt,
  output logic             tc,
  output logic             wave
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             run_n, stop_q, stop_n, rel_q, rel_n;
  logic [LEN_W-1:0] cnt_n, len_q, len_n;
  logic [1:0]       mode_q, mode_n;

  assign tc = run && tick && (cnt == ONE);

  always_comb begin
    run_n  = run;
    cnt_n  = cnt;
    len_n  = len_q;
    mode_n = mode_q;
    stop_n = stop_q;
    rel_n  = rel_q;
    if (run && tick) begin
      if (cnt == ONE) begin
        if (rel_q) begin
          len_n  = pend_len;
          mode_n = pend_mode;
          cnt_n  = pend_len;
          rel_n  = 1'b0;
        end else if (stop_q || !mode_q[1]) begin
          run_n  = 1'b0;
          stop_n = 1'b0;
          cnt_n  = len_q;
        end else begin
          cnt_n  = len_q;
        end
      end else begin
        cnt_n = cnt - ONE;
      end
    end
    if (ctl_wr) begin
      unique case (tcmd)
        TC_HALT: if (run_n) begin
          run_n  = 1'b0;
          stop_n = 1'b0;
          rel_n  = 1'b0;
        end
        TC_DRAIN: if (run_n) begin
          stop_n = 1'b1;
          rel_n  = 1'b0;
        end
        TC_GO: if (run_n) begin
          rel_n  = 1'b1;
          stop_n = 1'b0;
        end else begin
          run_n  = 1'b1;
          len_n  = pend_len;
          mode_n = pend_mode;
          cnt_n  = pend_len;
          stop_n = 1'b0;
          rel_n  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      mode_q <= '0;
      stop_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      run    <= run_n;
      cnt    <= cnt_n;
      len_q  <= len_n;
      mode_q <= mode_n;
      stop_q <= stop_n;
      rel_q  <= rel_n;
    end
  end

  always_comb begin
    if (!run)           wave = 1'b1;
    else if (mode_q[0]) wave = (cnt > (len_q >> 1));
    else                wave = (cnt != ONE);
  end

  // R3
  halt_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && tcmd == TC_HALT) |=> !run);
  // R5
  go_idle_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && tcmd == TC_GO && !run) |=> (run && cnt == $past(pend_len)));
  // R8
  single_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !rel_q && !mode_q[1] && !ctl_wr) |=> !run);
  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt != ONE && !ctl_wr) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/ivt_stat.sv
module ivt_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tc,
  input  logic       stat_rd,
  input  logic [5:0] port_flags,
  output logic       flag,
  output logic [7:0] rdata
);
  logic flag_n;

  always_comb begin
    flag_n = flag;
    if (tc)           flag_n = 1'b1;
    else if (stat_rd) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_n;
  end

  assign rdata = stat_rd ? {1'b0, flag, port_flags} : 8'h00;

  // R10
  tc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag);
  // R10
  rd_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tc) |=> !flag);
endmodule

// File: rtl/ivt_cmd_unit.sv
module ivt_cmd_unit
  import ivt_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_io,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [5:0]       port_flags,
  input  logic             tmr_tick,
  output logic [3:0]       port_mode,
  output logic [1:0]       port_irq_en,
  output logic             tmr_out,
  output logic             tmr_run,
  output logic [LEN_W-1:0] tmr_count
);
  logic             rst_q1, rst_q2;
  logic             ctl_wr, stat_rd, tc, flag;
  tcmd_e            tcmd;
  logic [5:0]       cmd_q;
  logic [LEN_W-1:0] pend_len;
  logic [1:0]       pend_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  ivt_bus_dec #(.LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst_n(rst_q2), .cs(bus_cs), .io(bus_io), .wr(bus_wr),
    .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata), .ctl_wr(ctl_wr),
    .stat_rd(stat_rd), .tcmd(tcmd), .cmd_q(cmd_q), .pend_len(pend_len),
    .pend_mode(pend_mode)
  );

  ivt_run_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_q2), .tick(tmr_tick), .ctl_wr(ctl_wr),
    .tcmd(tcmd), .pend_len(pend_len), .pend_mode(pend_mode),
    .run(tmr_run), .cnt(tmr_count), .tc(tc), .wave(tmr_out)
  );

  ivt_stat u_stat (
    .clk(clk), .rst_n(rst_q2), .tc(tc), .stat_rd(stat_rd),
    .port_flags(port_flags), .flag(flag), .rdata(bus_rdata)
  );

  assign port_mode   = cmd_q[3:0];
  assign port_irq_en = cmd_q[5:4];
endmodule

// File: tb/test_ivt_cmd_unit.sv
module test_ivt_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 0, bus_io = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [5:0]  port_flags = 0;
  logic        tmr_tick = 0;
  logic [3:0]  port_mode;
  logic [1:0]  port_irq_en;
  logic        tmr_out, tmr_run;
  logic [13:0] tmr_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rd_v;

  always #10 clk = ~clk;

  ivt_cmd_unit i_ivt_cmd_unit (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_io(bus_io),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_flags(port_flags),
    .tmr_tick(tmr_tick), .port_mode(port_mode), .port_irq_en(port_irq_en),
    .tmr_out(tmr_out), .tmr_run(tmr_run), .tmr_count(tmr_count)
  );

  // vector: len[25:12], mode[11:10], ticks[9:2], exp_run[1], exp_flag[0]
  localparam logic [25:0] VEC [8] = '{
    {14'd5,   2'b00, 8'd4,   1'b1, 1'b0},
    {14'd5,   2'b00, 8'd5,   1'b0, 1'b1},
    {14'd3,   2'b01, 8'd3,   1'b0, 1'b1},
    {14'd4,   2'b10, 8'd4,   1'b1, 1'b1},
    {14'd4,   2'b11, 8'd9,   1'b1, 1'b1},
    {14'd6,   2'b11, 8'd5,   1'b1, 1'b0},
    {14'd2,   2'b00, 8'd1,   1'b1, 1'b0},
    {14'd260, 2'b10, 8'd200, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_io = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_io = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic io, input logic [2:0] a, input logic tk);
    @(negedge clk);
    bus_cs = 1; bus_io = io; bus_rd = 1; bus_addr = a; tmr_tick = tk;
    #2 rd_v = bus_rdata;
    @(negedge clk);
    bus_cs = 0; bus_io = 0; bus_rd = 0; tmr_tick = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tmr_tick = 1;
    repeat (n) @(negedge clk);
    tmr_tick = 0;
  endtask

  task automatic set_len(input int len, input logic [1:0] mode);
    wr(3'd4, len[7:0]);
    wr(3'd5, {mode, len[13:8]});
  endtask

  task automatic fresh(input int len, input logic [1:0] mode);
    wr(3'd0, 8'h40);
    rd(1, 3'd0, 0);
    set_len(len, mode);
    wr(3'd0, 8'hC0);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 R10 reset state
    check("R1 reset port_mode", port_mode, 0);
    check("R1 reset irq_en", port_irq_en, 0);
    check("R3 reset run", tmr_run, 0);
    check("R12 idle out", tmr_out, 1);
    rd(1, 3'd0, 0);
    check("R10 reset status", rd_v, 0);

    // R9 status format and decode
    port_flags = 6'h2A;
    rd(1, 3'd0, 0);
    check("R9 port flags", rd_v, 8'h2A);
    rd(0, 3'd0, 0);
    check("R9 memory space read", rd_v, 0);
    port_flags = 0;

    // R1 R2 command bits stored, timer untouched
    wr(3'd0, 8'b00_11_0101);
    check("R1 port_mode", port_mode, 5);
    check("R1 irq_en", port_irq_en, 3);
    check("R2 nop idle", tmr_run, 0);

    // R3 R4 idle no effect
    wr(3'd0, 8'h40);
    check("R3 halt idle", tmr_run, 0);
    wr(3'd0, 8'h80);
    ticks(6);
    check("R4 drain idle", tmr_run, 0);
    rd(1, 3'd0, 0);
    check("R4 drain idle flag", rd_v[6], 0);

    // table: R5 R8 R11
    for (int i = 0; i < 8; i++) begin
      int len, n, ecnt;
      len = int'(VEC[i][25:12]);
      n   = int'(VEC[i][9:2]);
      fresh(len, VEC[i][11:10]);
      check("R5 start count", tmr_count, len);
      ticks(n);
      ecnt = VEC[i][1] ? len - (n % len) : len;
      check("R8 run after ticks", tmr_run, VEC[i][1]);
      check("R11 count after ticks", tmr_count, ecnt);
      rd(1, 3'd0, 0);
      check("R10 flag after ticks", rd_v[6], VEC[i][0]);
    end

    // R4 drain while running
    fresh(5, 2'b10);
    ticks(2);
    wr(3'd0, 8'h80);
    ticks(2);
    check("R4 still running", tmr_run, 1);
    ticks(1);
    check("R4 stopped at tc", tmr_run, 0);
    rd(1, 3'd0, 0);
    check("R4 flag", rd_v[6], 1);

    // R6 deferred reload
    fresh(5, 2'b10);
    ticks(1);
    set_len(3, 2'b01);
    wr(3'd0, 8'hC0);
    check("R6 count untouched", tmr_count, 4);
    ticks(4);
    check("R6 reload length", tmr_count, 3);
    check("R6 keeps running", tmr_run, 1);
    rd(1, 3'd0, 0);
    ticks(3);
    check("R6 new mode single stops", tmr_run, 0);
    rd(1, 3'd0, 0);
    check("R6 second tc flag", rd_v[6], 1);

    // R7 later command wins
    fresh(4, 2'b10);
    set_len(6, 2'b10);
    wr(3'd0, 8'h80);
    wr(3'd0, 8'hC0);
    ticks(4);
    check("R7 go replaces drain", tmr_run, 1);
    check("R7 go reload", tmr_count, 6);
    wr(3'd0, 8'hC0);
    wr(3'd0, 8'h80);
    ticks(6);
    check("R7 drain replaces go", tmr_run, 0);

    // R3 halt while running
    fresh(8, 2'b10);
    ticks(3);
    wr(3'd0, 8'h40);
    check("R3 halt running", tmr_run, 0);
    check("R3 count held", tmr_count, 5);
    ticks(3);
    check("R3 count stays", tmr_count, 5);

    // R2 nop while running
    fresh(8, 2'b10);
    ticks(2);
    wr(3'd0, 8'h00);
    ticks(1);
    check("R2 nop keeps counting", tmr_count, 5);

    // R10 read coinciding with terminal count
    fresh(3, 2'b10);
    ticks(2);
    rd(1, 3'd0, 1);
    check("R10 coincide old value", rd_v[6], 0);
    rd(1, 3'd0, 0);
    check("R10 flag kept", rd_v[6], 1);
    rd(1, 3'd0, 0);
    check("R10 cleared by read", rd_v[6], 0);

    // R12 waveforms
    fresh(4, 2'b00);
    check("R12 pulse high", tmr_out, 1);
    ticks(3);
    check("R12 pulse low at 1", tmr_out, 0);
    fresh(4, 2'b01);
    ticks(1);
    check("R12 square high at 3", tmr_out, 1);
    ticks(1);
    check("R12 square low at 2", tmr_out, 0);

    // R10 R1 reset mid-run clears flag
    fresh(2, 2'b10);
    ticks(3);
    wr(3'd0, 8'hFF);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R3 reset stops", tmr_run, 0);
    check("R1 reset clears cmd", port_mode, 0);
    rd(1, 3'd0, 0);
    check("R10 reset clears flag", rd_v[6], 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule